// File: doc/BRIEF.md
# Prefetching Single-Clock FIFO

This block is a synchronous first-in first-out buffer. It moves the oldest stored word into an output register by itself, without waiting for the consumer to ask. The consumer sees a word together with a valid flag. It uses the word straight away, then pulses an acknowledge to say the word has been consumed. The block reloads the output register from memory in that same clock edge when another word is stored. If no word is stored, the valid flag drops.

Storage is a dual-port array addressed by a write pointer and a read pointer. Each pointer carries one extra wrap bit. The full flag covers the array only. With a valid word waiting in the output register, the buffer therefore holds DEPTH+1 words in total. Read data always comes from a register on the shared clock, so the output timing matches a plain registered FIFO.

Top module: `fwft_fifo`

## Requirements
- R1: While rst_ni is low, and after it is released with no traffic, rd_valid_o and full_o are both 0.
- R2: rd_valid_o reports the output register only. Whenever it is 0 at a clock edge and the array holds a word, that edge loads the oldest word into rd_data_o and sets rd_valid_o to 1, with take_i not required.
- R3: A word written into an empty buffer is stored at edge k. It appears on rd_data_o with rd_valid_o = 1 after edge k+1, which is within two cycles.
- R4: take_i = 1 while rd_valid_o = 1 and the array holds a word loads the next word at that edge, and rd_valid_o stays 1.
- R5: take_i = 1 while rd_valid_o = 1 and the array is empty clears rd_valid_o at that edge.
- R6: take_i while rd_valid_o = 0 has no effect: no word is skipped or lost.
- R7: full_o is 1 exactly when the array holds DEPTH words, not counting the output register. A write while full_o = 1 is dropped, and the write pointer does not move.
- R8: take_i, together with a write into an empty array in the same cycle, clears rd_valid_o at that edge. The written word is presented on the next edge.
- R9: Words leave in the order they were accepted, under any mix of writes and acknowledges.
- R10: While rd_valid_o = 1 and take_i = 0, rd_data_o and rd_valid_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| full_o | output | 1 | Array holds DEPTH words |
| take_i | input | 1 | Consumer acknowledge for the word shown |
| rd_data_o | output | DW | Registered output word |
| rd_valid_o | output | 1 | rd_data_o holds a valid word |

## Verification
Two events can land in the same edge: the consumer's acknowledge and a write into an empty array. In that edge, the refill has nothing to fetch and the new word is only just being stored. A directed step provokes this by leaving one word in the output register and then driving take_i and wr_en_i together. The bench expects rd_valid_o to drop for exactly one cycle and then show the new word. Random traffic also hits the case repeatedly. A cycle-by-cycle queue model judges every edge on valid, data and full.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_HOLD = 1'b1
  } rd_state_e;
endpackage

// File: rtl/fwft_mem.sv
module fwft_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl #(
  parameter int AW = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [AW:0] rd_ptr_i,
  output logic [AW:0] wr_ptr_o,
  output logic        push_o,
  output logic        full_o
);
  logic [AW:0] wr_ptr_q;

  assign full_o   = (wr_ptr_q[AW] != rd_ptr_i[AW]) &&
                    (wr_ptr_q[AW-1:0] == rd_ptr_i[AW-1:0]);
  assign push_o   = wr_en_i && !full_o;
  assign wr_ptr_o = wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wr_ptr_q <= '0;
    else if (push_o) wr_ptr_q <= wr_ptr_q + 1'b1;
  end
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl
  import fwft_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW:0]   wr_ptr_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW:0]   rd_ptr_o,
  output logic          mem_empty_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  rd_state_e   state_q, state_d;
  logic [AW:0] rd_ptr_q;
  logic [DW-1:0] data_q;
  logic        load;

  assign mem_empty_o = (wr_ptr_i == rd_ptr_q);
  // refill when output slot is free or being freed this edge
  assign load = !mem_empty_o && ((state_q == RD_IDLE) || take_i);

  always_comb begin
    state_d = state_q;
    if (load)                             state_d = RD_HOLD;
    else if (state_q == RD_HOLD && take_i) state_d = RD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RD_IDLE;
      rd_ptr_q <= '0;
      data_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        data_q   <= mem_rdata_i;
        rd_ptr_q <= rd_ptr_q + 1'b1;
      end
    end
  end

  assign rd_ptr_o   = rd_ptr_q;
  assign rd_data_o  = data_q;
  assign rd_valid_o = (state_q == RD_HOLD);
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          take_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          push, mem_empty;
  logic [DW-1:0] mem_rdata;

  fwft_wr_ctrl #(.AW(AW)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_ptr_i(rd_ptr),
    .wr_ptr_o(wr_ptr),
    .push_o  (push),
    .full_o  (full_o)
  );

  fwft_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (push),
    .waddr_i(wr_ptr[AW-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rd_ptr[AW-1:0]),
    .rdata_o(mem_rdata)
  );

  fwft_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take_i),
    .wr_ptr_i   (wr_ptr),
    .mem_rdata_i(mem_rdata),
    .rd_ptr_o   (rd_ptr),
    .mem_empty_o(mem_empty),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          take_i,
  input logic          full_o,
  input logic          rd_valid_o,
  input logic [DW-1:0] rd_data_o,
  input logic          mem_empty,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr
);
  p_prefetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_o && !mem_empty) |=> rd_valid_o);

  p_refill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && take_i && !mem_empty) |=> (rd_valid_o && rd_ptr == $past(rd_ptr) + 1'b1));

  p_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && take_i && mem_empty) |=> !rd_valid_o);

  p_ignore_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_o && take_i && mem_empty) |=> (!rd_valid_o && $stable(rd_ptr)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i) |=> $stable(wr_ptr));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !take_i) |=> (rd_valid_o && $stable(rd_data_o)));
endmodule

bind fwft_fifo fwft_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .take_i    (take_i),
  .full_o    (full_o),
  .rd_valid_o(rd_valid_o),
  .rd_data_o (rd_data_o),
  .mem_empty (mem_empty),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr)
);

// File: tb/fwft_fifo_tb_top.sv
module fwft_fifo_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          take = 1'b0;
  logic          full;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state
  logic [DW-1:0] m_q[$];
  logic          m_valid = 1'b0;
  logic [DW-1:0] m_data  = '0;

  always #4 clk = ~clk;  // 125 MHz

  fwft_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .full_o    (full),
    .take_i    (take),
    .rd_data_o (rd_data),
    .rd_valid_o(rd_valid)
  );

  function automatic bit exp_full();
    return m_q.size() == DEPTH;
  endfunction

  task automatic check(input string tag);
    n_checks++;
    if (rd_valid !== m_valid || full !== exp_full() ||
        (m_valid && rd_data !== m_data)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b full=%0b data=%h expected valid=%0b full=%0b data=%h",
               tag, rd_valid, full, rd_data, m_valid, exp_full(), m_data);
    end
  endtask

  // drive at negedge, model the posedge, compare at next negedge
  task automatic step(input bit w, input logic [DW-1:0] d, input bit t, input string tag);
    bit f, ld;
    wr_en = w; wr_data = d; take = t;
    @(posedge clk);
    f  = exp_full();
    ld = (m_q.size() > 0) && (!m_valid || t);
    if (ld) begin
      m_data  = m_q.pop_front();
      m_valid = 1'b1;
    end else if (t && m_valid) begin
      m_valid = 1'b0;
    end
    if (w && !f) m_q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0; take = 1'b0;
    check(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step(0, '0, 1, "R6 take while empty");
    step(1, 16'hA001, 0, "R3 edge of write, not yet valid");
    step(0, '0, 0, "R3 R2 prefetched");
    step(0, '0, 0, "R10 hold");
    step(0, '0, 0, "R10 hold");
    step(1, 16'hB002, 0, "R10 hold with write");
    step(1, 16'hC003, 0, "R10 hold with write");
    step(0, '0, 1, "R4 refill B");
    step(0, '0, 1, "R4 refill C");
    step(0, '0, 1, "R5 drain");
    step(0, '0, 1, "R6 take while empty");

    step(1, 16'hD004, 0, "R3 write");
    step(0, '0, 0, "R3 shown");
    step(1, 16'hE005, 1, "R8 take with write to empty array");
    step(0, '0, 0, "R8 new word shown");
    step(0, '0, 1, "R5 drain");

    for (int i = 0; i < 7; i++)
      step(1, 16'hF000 + 16'(i), 0, "R7 fill");
    step(1, 16'hDEAD, 0, "R7 write while full dropped");
    for (int i = 0; i < 7; i++)
      step(0, '0, 1, "R9 R7 drain order");

    for (int i = 0; i < 3000; i++)
      step(($urandom % 2) == 0, 16'($urandom), ($urandom % 3) != 0, "R9 random");
    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) != 0, 16'($urandom), ($urandom % 4) == 0, "R9 R7 random high fill");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule